// File: doc/BRIEF.md
# Parallel Port Mode and Interrupt Control

This block is the register-level core of a legacy host-side parallel port. The host reaches four byte-wide registers over a simple read/write strobe bus: a data latch, a device status register, a device control register and an extended control register. A three-bit mode field in the extended control register selects the port personality. From that field and the control register the block works out the following registered outputs:

- the data-bus output enable,
- the byte to drive onto the data lines,
- a per-pin selection between push-pull and open-drain for the four host control pins,
- two flags that tell the neighbouring handshake engines when their mode is active.

The block also owns the port interrupt. The acknowledge input is synchronised, and its rising edges are detected. When enabled, such an edge latches a status flag and pulls an active-low interrupt line. The flag stays set until the host reads the status register. The handshake sequencing of the enhanced and extended modes lives elsewhere. This block only reports that those modes are selected.

Top module: `lpt_mode_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `pd_oe` is 1, `pd_out` is 0, all `ctl_push_pull` bits are 0, `mode_epp` and `mode_ecp` are 0, and `irq_n` is 1.
- R2: With mode code 3'b000 (output-only), `pd_oe` is 1 whatever control bit 5 holds. `pd_out` carries the data register. Every mode-derived output updates on the clock edge after the register write takes effect.
- R3: With mode code 3'b001 (bidirectional), `pd_oe` is the inverse of control bit 5: 1 in that bit selects input, 0 selects output.
- R4: With mode code 3'b100, all four `ctl_push_pull` bits are 1 (push-pull). With any other code they are all 0 (open-drain).
- R5: `mode_epp` is 1 only for code 3'b100, and `mode_ecp` is 1 only for code 3'b011. The two are never high together. In both modes the data direction follows control bit 5 as in R3.
- R6: Codes 3'b010, 3'b101, 3'b110 and 3'b111 behave as code 3'b000: data driven, pins open-drain, no mode flag.
- R7: The register addresses are 0 data, 1 status, 2 control and 3 extended control. The mode field is bits [7:5] of the extended control register. `rd_data` presents the addressed register on the edge that samples `rd_en`. Status reads back zero in every bit except bit 2.
- R8: With control bit 4 set, a rising edge on `ack_in` sets status bit 2 and drives `irq_n` low. This happens on the fourth clock edge after `ack_in` rises, counting two synchroniser stages, the flag and the output register. A falling edge, or a rising edge while bit 4 is clear, has no effect.
- R9: A status read returns bit 2 as it stood before the read, clears it, and releases `irq_n` on the following edge.
- R10: A detected rising edge that falls on the same edge as a status read wins. The flag stays set and `irq_n` stays low.
- R11: Clearing control bit 4 clears the flag and raises `irq_n` on the edge after the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ack_in | input | 1 | Acknowledge line from the peripheral (asynchronous) |
| pd_out | output | 8 | Byte for the data lines |
| pd_oe | output | 1 | Data-line output enable |
| ctl_push_pull | output | 4 | 1 = push-pull, 0 = open-drain, one bit per control pin |
| mode_epp | output | 1 | Enhanced mode selected |
| mode_ecp | output | 1 | Extended mode selected |
| irq_n | output | 1 | Active-low port interrupt |

## Verification
The bench targets the same-edge collision of a detected acknowledge edge and a status read. A design that gives the read priority would release `irq_n` and lose an event. The bench also sets control bit 5 under the output-only and fallback codes. A design that applied bidirectional direction to every mode would then float the data lines. Further checks cover an acknowledge edge arriving while disabled and a falling acknowledge edge; a design that latched either would raise a spurious interrupt. Disabling with a request pending is checked as well: a design that only masked the output would leave status bit 2 set.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int N_CTL_PIN = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_EXT  = 2'd3;

  localparam int MODE_LSB = 5;
  localparam int MODE_W   = 3;
  localparam int DIR_BIT  = 5;
  localparam int IEN_BIT  = 4;
  localparam int FLAG_BIT = 2;

  localparam logic [MODE_W-1:0] MODE_SPP = 3'b000;
  localparam logic [MODE_W-1:0] MODE_PS2 = 3'b001;
  localparam logic [MODE_W-1:0] MODE_ECP = 3'b011;
  localparam logic [MODE_W-1:0] MODE_EPP = 3'b100;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic              flag,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     data_q,
  output logic [MODE_W-1:0] mode_code,
  output logic              dir_bit,
  output logic              ien_bit,
  output logic              stat_rd
);
  logic [DW-1:0] ctrl_q, ext_q, stat_v;

  always_comb begin
    stat_v           = '0;
    stat_v[FLAG_BIT] = flag;
  end

  assign stat_rd   = rd && (addr == ADR_STAT);
  assign mode_code = ext_q[MODE_LSB +: MODE_W];
  assign dir_bit   = ctrl_q[DIR_BIT];
  assign ien_bit   = ctrl_q[IEN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctrl_q <= '0;
      ext_q  <= '0;
    end else if (wr) begin
      case (addr)
        ADR_DATA: data_q <= wdata;
        ADR_CTRL: ctrl_q <= wdata;
        ADR_EXT:  ext_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        ADR_DATA: rdata <= data_q;
        ADR_STAT: rdata <= stat_v;
        ADR_CTRL: rdata <= ctrl_q;
        default:  rdata <= ext_q;
      endcase
    end
  end

  assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_CTRL) |=> (dir_bit == $past(wdata[DIR_BIT]) && ien_bit == $past(wdata[IEN_BIT])));
endmodule

// File: rtl/lpt_mode_dec.sv
module lpt_mode_dec
  import lpt_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NPINS = N_CTL_PIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              dir_bit,
  input  logic [DW-1:0]     data_in,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  output logic [NPINS-1:0]  pp_sel,
  output logic              is_epp,
  output logic              is_ecp
);
  logic epp_d, ecp_d, bidir_d;

  always_comb begin
    epp_d   = (mode_code == MODE_EPP);
    ecp_d   = (mode_code == MODE_ECP);
    bidir_d = (mode_code == MODE_PS2) || epp_d || ecp_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_out <= '0;
      pd_oe  <= 1'b1;
      is_epp <= 1'b0;
      is_ecp <= 1'b0;
    end else begin
      pd_out <= data_in;
      pd_oe  <= bidir_d ? ~dir_bit : 1'b1;
      is_epp <= epp_d;
      is_ecp <= ecp_d;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pp_sel[p] <= 1'b0;
      else     pp_sel[p] <= epp_d;
    end
  end

  assert_spp_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_SPP) |=> pd_oe);
  assert_ps2_dir_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_PS2) |=> (pd_oe == !$past(dir_bit)));
  assert_epp_pp_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_EPP) |=> (pp_sel == {NPINS{1'b1}}));
  assert_od_else_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_code != MODE_EPP) |=> (pp_sel == '0));
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_epp, is_ecp}));
  assert_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_code inside {3'b010, 3'b101, 3'b110, 3'b111}) |=> (pd_oe && !is_epp && !is_ecp));
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_async,
  input  logic enable,
  input  logic stat_rd,
  output logic flag,
  output logic irq_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst)        sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= ack_async;
      else            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (!enable)      flag <= 1'b0;
      else if (rise)    flag <= 1'b1;
      else if (stat_rd) flag <= 1'b0;
      irq_n <= ~(flag & enable);
    end
  end

  assert_edge_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (enable && rise) |=> flag);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rise) |=> !flag);
  assert_race_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (enable && rise && stat_rd) |=> flag);
  assert_disable_R11: assert property (@(posedge clk) disable iff (rst)
    (!enable) |=> irq_n);
endmodule

// File: rtl/lpt_mode_ctrl.sv
module lpt_mode_ctrl
  import lpt_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int AW          = ADDR_W,
  parameter int NPINS       = N_CTL_PIN,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic             ack_in,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe,
  output logic [NPINS-1:0] ctl_push_pull,
  output logic             mode_epp,
  output logic             mode_ecp,
  output logic             irq_n
);
  logic [DW-1:0]     data_q;
  logic [MODE_W-1:0] mode_code;
  logic              dir_bit, ien_bit, stat_rd, flag;

  lpt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(wr_en), .rd(rd_en),
    .wdata(wr_data), .flag(flag), .rdata(rd_data), .data_q(data_q),
    .mode_code(mode_code), .dir_bit(dir_bit), .ien_bit(ien_bit),
    .stat_rd(stat_rd)
  );

  lpt_mode_dec #(.DW(DW), .NPINS(NPINS)) u_dec (
    .clk(clk), .rst(rst), .mode_code(mode_code), .dir_bit(dir_bit),
    .data_in(data_q), .pd_out(pd_out), .pd_oe(pd_oe),
    .pp_sel(ctl_push_pull), .is_epp(mode_epp), .is_ecp(mode_ecp)
  );

  lpt_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst(rst), .ack_async(ack_in), .enable(ien_bit),
    .stat_rd(stat_rd), .flag(flag), .irq_n(irq_n)
  );
endmodule

// File: tb/lpt_mode_ctrl_bench.sv
module lpt_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ack_in = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, pd_out;
  logic       pd_oe, mode_epp, mode_ecp, irq_n;
  logic [3:0] ctl_push_pull;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  lpt_mode_ctrl u_lpt_mode_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .ack_in(ack_in), .pd_out(pd_out),
    .pd_oe(pd_oe), .ctl_push_pull(ctl_push_pull), .mode_epp(mode_epp),
    .mode_ecp(mode_ecp), .irq_n(irq_n)
  );

  function automatic logic [7:0] actual(int sel);
    case (sel)
      0: return pd_out;
      1: return {7'd0, pd_oe};
      2: return {4'd0, ctl_push_pull};
      3: return {6'd0, mode_ecp, mode_epp};
      4: return {7'd0, irq_n};
      default: return rd_data;
    endcase
  endfunction

  task automatic expect_item(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] a;
      it = q.pop_front();
      a  = actual(it.sel);
      n_run++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, a, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    expect_item(req, 5, exp);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    expect_item("R1 pd_oe", 1, 8'h01);
    expect_item("R1 pd_out", 0, 8'h00);
    expect_item("R1 pull", 2, 8'h00);
    expect_item("R1 flags", 3, 8'h00);
    expect_item("R1 irq_n", 4, 8'h01);
    expect_item("R1 rd_data", 5, 8'h00);
    // R2 output-only mode
    wr(2'd0, 8'hA5); tick(1);
    expect_item("R2 pd_out", 0, 8'hA5);
    expect_item("R2 pd_oe", 1, 8'h01);
    wr(2'd2, 8'h20); tick(1);
    expect_item("R2 dir bit ignored", 1, 8'h01);
    // R3 bidirectional
    wr(2'd3, 8'h20); tick(1);
    expect_item("R3 input", 1, 8'h00);
    wr(2'd2, 8'h00); tick(1);
    expect_item("R3 output", 1, 8'h01);
    // R4 R5 enhanced
    wr(2'd3, 8'h80); tick(1);
    expect_item("R4 push-pull", 2, 8'h0F);
    expect_item("R5 epp flag", 3, 8'h01);
    wr(2'd2, 8'h20); tick(1);
    expect_item("R5 epp dir", 1, 8'h00);
    // extended
    wr(2'd3, 8'h60); tick(1);
    expect_item("R4 open-drain", 2, 8'h00);
    expect_item("R5 ecp flag", 3, 8'h02);
    expect_item("R5 ecp dir", 1, 8'h00);
    // R6 fallback codes
    wr(2'd3, 8'hE0); tick(1);
    expect_item("R6 code7 drive", 1, 8'h01);
    expect_item("R6 code7 pull", 2, 8'h00);
    expect_item("R6 code7 flags", 3, 8'h00);
    wr(2'd3, 8'h40); tick(1);
    expect_item("R6 code2 drive", 1, 8'h01);
    // R7 readback
    rd(2'd0, "R7 data", 8'hA5);
    rd(2'd2, "R7 ctrl", 8'h20);
    rd(2'd3, "R7 ext", 8'h40);
    rd(2'd1, "R7 status", 8'h00);
    // R8 disabled edge ignored
    ack_in = 1'b1; tick(4);
    expect_item("R8 disabled irq_n", 4, 8'h01);
    rd(2'd1, "R8 disabled status", 8'h00);
    ack_in = 1'b0; tick(4);
    // R8 enabled
    wr(2'd2, 8'h10);
    ack_in = 1'b1; tick(4);
    expect_item("R8 irq low", 4, 8'h00);
    // R9 read clears
    rd(2'd1, "R9 status set", 8'h04);
    tick(1);
    expect_item("R9 irq released", 4, 8'h01);
    rd(2'd1, "R9 status cleared", 8'h00);
    // R8 falling edge ignored
    ack_in = 1'b0; tick(4);
    expect_item("R8 falling edge", 4, 8'h01);
    // R10 race
    ack_in = 1'b1; tick(2);
    rd(2'd1, "R10 read at edge", 8'h00);
    tick(1);
    expect_item("R10 irq kept", 4, 8'h00);
    rd(2'd1, "R10 flag kept", 8'h04);
    tick(1);
    // R11 disable with pending
    ack_in = 1'b0; tick(4);
    ack_in = 1'b1; tick(4);
    expect_item("R11 pending", 4, 8'h00);
    wr(2'd2, 8'h00); tick(1);
    expect_item("R11 irq released", 4, 8'h01);
    rd(2'd1, "R11 flag cleared", 8'h00);
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule